// File: doc/BRIEF.md
# 64-bit Integer and Bit-Manipulation ALU

This block is the integer execution stage for scalar instructions. It takes two 64-bit operands and an 8-bit operation code. It returns a 64-bit result one cycle later, with a valid flag that travels with the result. The operation set covers:

- 64-bit shifts and rotates
- single-bit clear, set, invert and extract
- 32-bit word arithmetic whose result is sign-extended
- fused word sums cut down to a bit, a byte or a halfword
- address-style shift-and-add
- compare, min and max
- bitwise logic with negated forms, byte packing and byte reversal

The block is fed by an issue stage that has already read and forwarded the operands. No stall path exists: every valid input produces a valid output on the next cycle. Codes outside the supported set return zero and raise a flag, so the surrounding pipeline can trap them.

Internally three operation units (shift, arithmetic, logic) decode the code in parallel. At most one of them claims an operation. The claimed result is merged into a single output register.

Top module: `xbit_alu`

## Requirements
- R1: After reset `out_vld`, `out_res` and `out_bad` are 0. A cycle with `in_vld` high produces `out_vld` high on the following cycle, carrying the result of that cycle's code and operands.
- R2: 64-bit shifts and rotates use src2[5:0] as the amount. The codes are:
  - 0x00: `a[31:0]` zero-extended, then shifted left
  - 0x01: shift left
  - 0x05: logical shift right
  - 0x07: arithmetic shift right
  - 0x09: rotate left
  - 0x0B: rotate right
- R3: Single-bit operations use src2[5:0] as the bit index. The codes are 0x02 clear bit, 0x03 set bit, 0x04 invert bit, and 0x06 extract bit. Extract returns 0 or 1.
- R4: Word operations compute on 32 bits and sign-extend bit 31 into bits 63:32. Shift amounts come from src2[4:0], and right shifts see only `a[31:0]`. The codes are:
  - 0x10: add
  - 0x11: `a[0]` plus src2
  - 0x12: subtract
  - 0x18: shift left
  - 0x19: logical shift right
  - 0x1A: arithmetic shift right
  - 0x1C: rotate left
  - 0x1D: rotate right
- R5: Word-sum variants take the 32-bit sum `a+b` and keep only part of it:
  - 0x14: bit 0 of the sum
  - 0x15: low 8 bits, zero-extended
  - 0x16: low 16 bits, zero-extended
  - 0x17: low 16 bits, sign-extended
- R6: 64-bit add group:
  - 0x20: zero-extended `a[31:0]` plus b
  - 0x21: a plus b
  - 0x22: `a[0]` plus b
  - 0x24 to 0x27: a logically shifted right by 29, 30, 31 or 32 bits, plus b
- R7: Shift-and-add. Codes 0x29, 0x2B, 0x2D and 0x2F add a shifted left by 1, 2, 3 or 4 to b. Codes 0x28, 0x2A and 0x2C zero-extend `a[31:0]` first, then shift left by 1, 2 or 3 and add b.
- R8: Compare group:
  - 0x30: a minus b
  - 0x31: unsigned less-than, returning 0 or 1
  - 0x32: signed less-than, returning 0 or 1
  - 0x34: unsigned max
  - 0x35: unsigned min
  - 0x36: signed max
  - 0x37: signed min
- R9: Logic group:
  - 0x40: and
  - 0x41: a and not b
  - 0x42: or
  - 0x43: a or not b
  - 0x44: xor
  - 0x45: xnor
  - 0x46: each byte of a becomes 0xFF if nonzero, else 0x00
- R10: Extension and packing:
  - 0x48: sign-extend `a[7:0]`
  - 0x49: `{48'b0, b[7:0], a[7:0]}`
  - 0x4A: sign-extend `a[15:0]`
  - 0x4B: sign-extend `{b[15:0], a[15:0]}` from bit 31
  - 0x51: reverse the byte order of a
- R11: Every code not listed in R2 to R10 gives `out_res` = 0 and `out_bad` = 1. This includes any code with bit 7 set. Listed codes give `out_bad` = 0.
- R12: A cycle with `in_vld` low gives `out_vld` low on the next cycle. In that cycle `out_res` and `out_bad` keep their previous values, whatever the operand and code inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation valid |
| in_op | input | 8 | Operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_res | output | 64 | Result |
| out_bad | output | 1 | Unsupported operation code |

## Verification
The bench sweeps all 256 codes against several kinds of operand: amounts of 0 and 63, src2 with high bits set beyond the amount field, sign-boundary operands, and random values.

Each targeted slip shows up as a distinct wrong value:

- A design that takes a word shift amount from six bits instead of five would shift to zero where a wrap was expected.
- A rotate by zero built from `a >> (64-s)` would smear the operand.
- A missed sign extension on a word result would leave bits 63:32 clear for negative sums.
- A signed compare done unsigned would pick the wrong operand of max/min across the sign boundary.
- An illegal code that leaked an operation unit's value would show a nonzero result with the flag set.

Idle cycles with toggling inputs expose an output register that loads when no valid input is present.

// File: rtl/xbit_alu_pkg.sv
package xbit_alu_pkg;
   // shift and single-bit group
   localparam logic [7:0] OP_SLLUW = 8'h00;
   localparam logic [7:0] OP_SLL   = 8'h01;
   localparam logic [7:0] OP_BCLR  = 8'h02;
   localparam logic [7:0] OP_BSET  = 8'h03;
   localparam logic [7:0] OP_BINV  = 8'h04;
   localparam logic [7:0] OP_SRL   = 8'h05;
   localparam logic [7:0] OP_BEXT  = 8'h06;
   localparam logic [7:0] OP_SRA   = 8'h07;
   localparam logic [7:0] OP_ROL   = 8'h09;
   localparam logic [7:0] OP_ROR   = 8'h0B;
   // word group
   localparam logic [7:0] OP_ADDW  = 8'h10;
   localparam logic [7:0] OP_OADDW = 8'h11;
   localparam logic [7:0] OP_SUBW  = 8'h12;
   localparam logic [7:0] OP_WBIT  = 8'h14;
   localparam logic [7:0] OP_WBYTE = 8'h15;
   localparam logic [7:0] OP_WZH   = 8'h16;
   localparam logic [7:0] OP_WSH   = 8'h17;
   localparam logic [7:0] OP_SLLW  = 8'h18;
   localparam logic [7:0] OP_SRLW  = 8'h19;
   localparam logic [7:0] OP_SRAW  = 8'h1A;
   localparam logic [7:0] OP_ROLW  = 8'h1C;
   localparam logic [7:0] OP_RORW  = 8'h1D;
   // add group
   localparam logic [7:0] OP_ADDUW = 8'h20;
   localparam logic [7:0] OP_ADD   = 8'h21;
   localparam logic [7:0] OP_OADD  = 8'h22;
   localparam logic [7:0] OP_SR0A  = 8'h24;
   localparam logic [7:0] OP_SH1U  = 8'h28;
   localparam logic [7:0] OP_SH1   = 8'h29;
   localparam logic [7:0] OP_SH2U  = 8'h2A;
   localparam logic [7:0] OP_SH2   = 8'h2B;
   localparam logic [7:0] OP_SH3U  = 8'h2C;
   localparam logic [7:0] OP_SH3   = 8'h2D;
   localparam logic [7:0] OP_SH4   = 8'h2F;
   // compare group
   localparam logic [7:0] OP_SUB   = 8'h30;
   localparam logic [7:0] OP_SLTU  = 8'h31;
   localparam logic [7:0] OP_SLT   = 8'h32;
   localparam logic [7:0] OP_MAXU  = 8'h34;
   localparam logic [7:0] OP_MINU  = 8'h35;
   localparam logic [7:0] OP_MAX   = 8'h36;
   localparam logic [7:0] OP_MIN   = 8'h37;
   // logic group
   localparam logic [7:0] OP_AND   = 8'h40;
   localparam logic [7:0] OP_ANDN  = 8'h41;
   localparam logic [7:0] OP_OR    = 8'h42;
   localparam logic [7:0] OP_ORN   = 8'h43;
   localparam logic [7:0] OP_XOR   = 8'h44;
   localparam logic [7:0] OP_XNOR  = 8'h45;
   localparam logic [7:0] OP_ORCB  = 8'h46;
   localparam logic [7:0] OP_SEXTB = 8'h48;
   localparam logic [7:0] OP_PACKH = 8'h49;
   localparam logic [7:0] OP_SEXTH = 8'h4A;
   localparam logic [7:0] OP_PACKW = 8'h4B;
   localparam logic [7:0] OP_REV8  = 8'h51;

   localparam int N_UNITS = 3;
   localparam int SR_STEPS = 4;
endpackage

// File: rtl/xbit_alu_shift.sv
module xbit_alu_shift
   import xbit_alu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [7:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res,
   output logic            hit
);
   localparam int SHW = $clog2(XLEN);
   localparam int HW  = XLEN / 2;
   localparam int HSW = SHW - 1;

   logic [SHW-1:0]    amt;
   logic [HSW-1:0]    wamt;
   logic [XLEN-1:0]   bit_mask;
   logic [2*XLEN-1:0] dbl, dbl_l, dbl_r;
   logic [HW-1:0]     lo;
   logic [2*HW-1:0]   wdbl, wdbl_l, wdbl_r;
   logic [HW-1:0]     w_sll, w_srl, w_sra;
   logic [XLEN-1:0]   lo_zx;

   assign amt      = b[SHW-1:0];
   assign wamt     = b[HSW-1:0];
   assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << amt;
   assign dbl      = {a, a};
   assign dbl_l    = dbl << amt;
   assign dbl_r    = dbl >> amt;
   assign lo       = a[HW-1:0];
   assign lo_zx    = {{HW{1'b0}}, lo};
   assign wdbl     = {lo, lo};
   assign wdbl_l   = wdbl << wamt;
   assign wdbl_r   = wdbl >> wamt;
   assign w_sll    = lo << wamt;
   assign w_srl    = lo >> wamt;
   assign w_sra    = HW'($signed(lo) >>> wamt);

   function automatic logic [XLEN-1:0] sx(input logic [HW-1:0] v);
      return {{HW{v[HW-1]}}, v};
   endfunction

   always_comb begin
      res = '0;
      hit = 1'b1;
      unique case (op)
         OP_SLLUW: res = lo_zx << amt;
         OP_SLL:   res = a << amt;
         OP_SRL:   res = a >> amt;
         OP_SRA:   res = XLEN'($signed(a) >>> amt);
         OP_ROL:   res = dbl_l[2*XLEN-1:XLEN];
         OP_ROR:   res = dbl_r[XLEN-1:0];
         OP_BCLR:  res = a & ~bit_mask;
         OP_BSET:  res = a | bit_mask;
         OP_BINV:  res = a ^ bit_mask;
         OP_BEXT:  res = {{(XLEN-1){1'b0}}, |(a & bit_mask)};
         OP_SLLW:  res = sx(w_sll);
         OP_SRLW:  res = sx(w_srl);
         OP_SRAW:  res = sx(w_sra);
         OP_ROLW:  res = sx(wdbl_l[2*HW-1:HW]);
         OP_RORW:  res = sx(wdbl_r[HW-1:0]);
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/xbit_alu_arith.sv
module xbit_alu_arith
   import xbit_alu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [7:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res,
   output logic            hit
);
   localparam int HW      = XLEN / 2;
   localparam int SR_BASE = HW - 3;
   localparam int SHK     = 4;

   logic [HW-1:0]   w_sum, w_odd, w_dif;
   logic [XLEN-1:0] a_zx, sum, odd_sum, dif;
   logic            lt_u, lt_s;
   logic [XLEN-1:0] sr_sum [SR_STEPS];
   logic [XLEN-1:0] sh_sum [SHK+1];
   logic [XLEN-1:0] shu_sum[SHK+1];

   assign w_sum   = a[HW-1:0] + b[HW-1:0];
   assign w_odd   = {{(HW-1){1'b0}}, a[0]} + b[HW-1:0];
   assign w_dif   = a[HW-1:0] - b[HW-1:0];
   assign a_zx    = {{HW{1'b0}}, a[HW-1:0]};
   assign sum     = a + b;
   assign odd_sum = {{(XLEN-1){1'b0}}, a[0]} + b;
   assign dif     = a - b;
   assign lt_u    = a < b;
   assign lt_s    = $signed(a) < $signed(b);

   for (genvar n = 0; n < SR_STEPS; n++) begin : g_sr
      assign sr_sum[n] = (a >> (SR_BASE + n)) + b;
   end

   assign sh_sum[0]  = sum;
   assign shu_sum[0] = a_zx + b;
   for (genvar k = 1; k <= SHK; k++) begin : g_sh
      assign sh_sum[k]  = (a << k) + b;
      assign shu_sum[k] = (a_zx << k) + b;
   end

   function automatic logic [XLEN-1:0] sx(input logic [HW-1:0] v);
      return {{HW{v[HW-1]}}, v};
   endfunction

   always_comb begin
      res = '0;
      hit = 1'b1;
      unique case (op)
         OP_ADDW:  res = sx(w_sum);
         OP_OADDW: res = sx(w_odd);
         OP_SUBW:  res = sx(w_dif);
         OP_WBIT:  res = {{(XLEN-1){1'b0}}, w_sum[0]};
         OP_WBYTE: res = {{(XLEN-8){1'b0}}, w_sum[7:0]};
         OP_WZH:   res = {{(XLEN-16){1'b0}}, w_sum[15:0]};
         OP_WSH:   res = {{(XLEN-16){w_sum[15]}}, w_sum[15:0]};
         OP_ADDUW: res = shu_sum[0];
         OP_ADD:   res = sum;
         OP_OADD:  res = odd_sum;
         OP_SH1U:  res = shu_sum[1];
         OP_SH1:   res = sh_sum[1];
         OP_SH2U:  res = shu_sum[2];
         OP_SH2:   res = sh_sum[2];
         OP_SH3U:  res = shu_sum[3];
         OP_SH3:   res = sh_sum[3];
         OP_SH4:   res = sh_sum[4];
         OP_SUB:   res = dif;
         OP_SLTU:  res = {{(XLEN-1){1'b0}}, lt_u};
         OP_SLT:   res = {{(XLEN-1){1'b0}}, lt_s};
         OP_MAXU:  res = lt_u ? b : a;
         OP_MINU:  res = lt_u ? a : b;
         OP_MAX:   res = lt_s ? b : a;
         OP_MIN:   res = lt_s ? a : b;
         default: begin
            if (op[7:2] == OP_SR0A[7:2]) res = sr_sum[op[1:0]];
            else                         hit = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/xbit_alu_logic.sv
module xbit_alu_logic
   import xbit_alu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [7:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res,
   output logic            hit
);
   localparam int NB = XLEN / 8;
   localparam int HW = XLEN / 2;

   logic [XLEN-1:0] orc, rev;
   logic [HW-1:0]   pk;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign orc[8*i +: 8] = {8{|a[8*i +: 8]}};
      assign rev[8*i +: 8] = a[8*(NB-1-i) +: 8];
   end

   assign pk = {{(HW-32){1'b0}}, b[15:0], a[15:0]};

   always_comb begin
      res = '0;
      hit = 1'b1;
      unique case (op)
         OP_AND:   res = a & b;
         OP_ANDN:  res = a & ~b;
         OP_OR:    res = a | b;
         OP_ORN:   res = a | ~b;
         OP_XOR:   res = a ^ b;
         OP_XNOR:  res = ~(a ^ b);
         OP_ORCB:  res = orc;
         OP_SEXTB: res = {{(XLEN-8){a[7]}}, a[7:0]};
         OP_PACKH: res = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
         OP_SEXTH: res = {{(XLEN-16){a[15]}}, a[15:0]};
         OP_PACKW: res = {{HW{pk[HW-1]}}, pk};
         OP_REV8:  res = rev;
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/xbit_alu.sv
module xbit_alu
   import xbit_alu_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int OUT_REG = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [7:0]      in_op,
   input  logic [XLEN-1:0] in_a,
   input  logic [XLEN-1:0] in_b,
   output logic            out_vld,
   output logic [XLEN-1:0] out_res,
   output logic            out_bad
);
   if (XLEN != 64) begin : g_chk_xlen
      $error("xbit_alu: XLEN must be 64");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_chk_reg
      $error("xbit_alu: OUT_REG must be 0 or 1");
   end

   logic [N_UNITS-1:0] unit_hit;
   logic [XLEN-1:0]    unit_res [N_UNITS];
   logic [XLEN-1:0]    nxt_res;
   logic               nxt_bad;

   xbit_alu_shift #(.XLEN(XLEN)) u_shift (
      .op(in_op), .a(in_a), .b(in_b), .res(unit_res[0]), .hit(unit_hit[0]));
   xbit_alu_arith #(.XLEN(XLEN)) u_arith (
      .op(in_op), .a(in_a), .b(in_b), .res(unit_res[1]), .hit(unit_hit[1]));
   xbit_alu_logic #(.XLEN(XLEN)) u_logic (
      .op(in_op), .a(in_a), .b(in_b), .res(unit_res[2]), .hit(unit_hit[2]));

   always_comb begin
      nxt_res = '0;
      for (int u = 0; u < N_UNITS; u++) begin
         if (unit_hit[u]) nxt_res = nxt_res | unit_res[u];
      end
      nxt_bad = ~|unit_hit;
   end

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
            out_bad <= 1'b0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) begin
               out_res <= nxt_res;
               out_bad <= nxt_bad;
            end
         end
      end
   end else begin : g_comb
      assign out_vld = in_vld;
      assign out_res = nxt_res;
      assign out_bad = nxt_bad;
   end
endmodule

// File: rtl/xbit_alu_chk.sv
module xbit_alu_chk
   import xbit_alu_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int OUT_REG = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_vld,
   input logic [7:0]         in_op,
   input logic               out_vld,
   input logic [XLEN-1:0]    out_res,
   input logic               out_bad,
   input logic [N_UNITS-1:0] unit_hit
);
   localparam int HW = XLEN / 2;

   logic is_word;
   assign is_word = in_op inside {OP_ADDW, OP_OADDW, OP_SUBW, OP_SLLW,
                                  OP_SRLW, OP_SRAW, OP_ROLW, OP_RORW};

   p_one_unit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unit_hit));

   p_bad_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_bad) |-> (out_res == '0));

   if (OUT_REG == 1) begin : g_seq
      p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);

      p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> (!out_vld && $stable(out_res) && $stable(out_bad)));

      p_bext_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && in_op == OP_BEXT) |=> (out_res[XLEN-1:1] == '0));

      p_word_sx_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && is_word) |=> (out_res[XLEN-1:HW] == {HW{out_res[HW-1]}}));

      p_wbit_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && in_op == OP_WBIT) |=> (out_res[XLEN-1:1] == '0 && !out_bad));
   end
endmodule

bind xbit_alu xbit_alu_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
   .out_vld(out_vld), .out_res(out_res), .out_bad(out_bad),
   .unit_hit(unit_hit));

// File: tb/sim_xbit_alu.sv
`timescale 1ns/1ps
module sim_xbit_alu;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_vld;
   logic [7:0]  in_op;
   logic [63:0] in_a, in_b;
   logic        out_vld;
   logic [63:0] out_res;
   logic        out_bad;

   int total = 0;
   int bad_n = 0;
   bit done = 1'b0;
   logic [63:0] held_res;
   logic        held_bad;

   always #2 clk = ~clk;

   xbit_alu u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_res(out_res),
      .out_bad(out_bad));

   function automatic logic [63:0] sx32(input logic [31:0] v);
      logic [63:0] r;
      r = {32'h0, v};
      if (v[31]) r[63:32] = 32'hFFFF_FFFF;
      return r;
   endfunction

   function automatic logic [31:0] rotl32(input logic [31:0] v, input int s);
      if (s == 0) return v;
      return (v << s) | (v >> (32 - s));
   endfunction

   // behavioural reference: returns result, illegal flag and requirement tag
   function automatic void model(input logic [7:0] op, input logic [63:0] a,
                                 input logic [63:0] b, output logic [63:0] r,
                                 output logic ill, output string tag);
      int s, w;
      logic [31:0] s32;
      s   = int'(b[5:0]);
      w   = int'(b[4:0]);
      s32 = a[31:0] + b[31:0];
      r   = 64'h0;
      ill = 1'b0;
      tag = "R11";
      case (op)
         8'h00: begin r = {32'h0, a[31:0]} << s; tag = "R2"; end
         8'h01: begin r = a << s; tag = "R2"; end
         8'h05: begin r = a >> s; tag = "R2"; end
         8'h07: begin r = a >> s; if (a[63] && s > 0) r = r | ~(64'hFFFF_FFFF_FFFF_FFFF >> s); tag = "R2"; end
         8'h09: begin r = (s == 0) ? a : ((a << s) | (a >> (64 - s))); tag = "R2"; end
         8'h0B: begin r = (s == 0) ? a : ((a >> s) | (a << (64 - s))); tag = "R2"; end
         8'h02: begin r = a; r[s] = 1'b0; tag = "R3"; end
         8'h03: begin r = a; r[s] = 1'b1; tag = "R3"; end
         8'h04: begin r = a; r[s] = ~a[s]; tag = "R3"; end
         8'h06: begin r = {63'h0, a[s]}; tag = "R3"; end
         8'h10: begin r = sx32(s32); tag = "R4"; end
         8'h11: begin r = sx32(b[31:0] + {31'h0, a[0]}); tag = "R4"; end
         8'h12: begin r = sx32(a[31:0] - b[31:0]); tag = "R4"; end
         8'h18: begin r = sx32(a[31:0] << w); tag = "R4"; end
         8'h19: begin r = sx32(a[31:0] >> w); tag = "R4"; end
         8'h1A: begin r = sx32(32'($signed(a[31:0]) >>> w)); tag = "R4"; end
         8'h1C: begin r = sx32(rotl32(a[31:0], w)); tag = "R4"; end
         8'h1D: begin r = sx32(rotl32(a[31:0], (32 - w) % 32)); tag = "R4"; end
         8'h14: begin r = {63'h0, s32[0]}; tag = "R5"; end
         8'h15: begin r = {56'h0, s32[7:0]}; tag = "R5"; end
         8'h16: begin r = {48'h0, s32[15:0]}; tag = "R5"; end
         8'h17: begin r = {{48{s32[15]}}, s32[15:0]}; tag = "R5"; end
         8'h20: begin r = {32'h0, a[31:0]} + b; tag = "R6"; end
         8'h21: begin r = a + b; tag = "R6"; end
         8'h22: begin r = b + {63'h0, a[0]}; tag = "R6"; end
         8'h24: begin r = (a >> 29) + b; tag = "R6"; end
         8'h25: begin r = (a >> 30) + b; tag = "R6"; end
         8'h26: begin r = (a >> 31) + b; tag = "R6"; end
         8'h27: begin r = (a >> 32) + b; tag = "R6"; end
         8'h29: begin r = b + (a << 1); tag = "R7"; end
         8'h2B: begin r = b + (a << 2); tag = "R7"; end
         8'h2D: begin r = b + (a << 3); tag = "R7"; end
         8'h2F: begin r = b + (a << 4); tag = "R7"; end
         8'h28: begin r = b + ({32'h0, a[31:0]} << 1); tag = "R7"; end
         8'h2A: begin r = b + ({32'h0, a[31:0]} << 2); tag = "R7"; end
         8'h2C: begin r = b + ({32'h0, a[31:0]} << 3); tag = "R7"; end
         8'h30: begin r = a - b; tag = "R8"; end
         8'h31: begin r = (a < b) ? 64'd1 : 64'd0; tag = "R8"; end
         8'h32: begin r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0; tag = "R8"; end
         8'h34: begin r = (a > b) ? a : b; tag = "R8"; end
         8'h35: begin r = (a > b) ? b : a; tag = "R8"; end
         8'h36: begin r = ($signed(a) > $signed(b)) ? a : b; tag = "R8"; end
         8'h37: begin r = ($signed(a) > $signed(b)) ? b : a; tag = "R8"; end
         8'h40: begin r = a & b; tag = "R9"; end
         8'h41: begin r = a & ~b; tag = "R9"; end
         8'h42: begin r = a | b; tag = "R9"; end
         8'h43: begin r = a | ~b; tag = "R9"; end
         8'h44: begin r = a ^ b; tag = "R9"; end
         8'h45: begin r = a ~^ b; tag = "R9"; end
         8'h46: begin
            for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 8'h0) ? 8'hFF : 8'h00;
            tag = "R9";
         end
         8'h48: begin r = {{56{a[7]}}, a[7:0]}; tag = "R10"; end
         8'h49: begin r = {48'h0, b[7:0], a[7:0]}; tag = "R10"; end
         8'h4A: begin r = {{48{a[15]}}, a[15:0]}; tag = "R10"; end
         8'h4B: begin r = sx32({b[15:0], a[15:0]}); tag = "R10"; end
         8'h51: begin
            for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
            tag = "R10";
         end
         default: begin r = 64'h0; ill = 1'b1; tag = "R11"; end
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad_n++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at a falling edge, compare at the next falling edge
   task automatic cyc(input bit v, input logic [7:0] op,
                      input logic [63:0] a, input logic [63:0] b);
      logic [63:0] er;
      logic        eb;
      string       tg;
      in_vld = v; in_op = op; in_a = a; in_b = b;
      model(op, a, b, er, eb, tg);
      @(negedge clk);
      if (v) begin
         check("R1", "out_vld", {63'h0, out_vld}, 64'd1);
         check(tg, $sformatf("op=%h res", op), out_res, er);
         check("R11", $sformatf("op=%h bad", op), {63'h0, out_bad}, {63'h0, eb});
         held_res = er;
         held_bad = eb;
      end else begin
         check("R12", "idle out_vld", {63'h0, out_vld}, 64'd0);
         check("R12", "idle hold res", out_res, held_res);
         check("R12", "idle hold bad", {63'h0, out_bad}, {63'h0, held_bad});
      end
   endtask

   initial begin
      #(4ns * 200000);
      if (!done) begin
         bad_n++;
         total++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad_n);
         $finish;
      end
   end

   initial begin
      logic [63:0] pa [8];
      logic [63:0] pb [8];
      rst_n = 1'b0; in_vld = 1'b0; in_op = 8'h0; in_a = 64'h0; in_b = 64'h0;
      repeat (3) @(negedge clk);
      check("R1", "reset out_vld", {63'h0, out_vld}, 64'd0);
      check("R1", "reset out_res", out_res, 64'd0);
      check("R1", "reset out_bad", {63'h0, out_bad}, 64'd0);
      held_res = 64'h0;
      held_bad = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      pa[0] = 64'h8000_0000_8000_0001; pb[0] = 64'h0;
      pa[1] = 64'hFEDC_BA98_7654_3210; pb[1] = 64'd63;
      pa[2] = 64'h0123_4567_89AB_CDEF; pb[2] = 64'hFFFF_FFFF_FFFF_FFE0;
      pa[3] = 64'hFFFF_FFFF_FFFF_FFFF; pb[3] = 64'd1;
      pa[4] = 64'h7FFF_FFFF_FFFF_FFFF; pb[4] = 64'h8000_0000_0000_0000;
      pa[5] = 64'h0000_0000_7FFF_FFFF; pb[5] = 64'h0000_0000_0000_8001;
      pa[6] = 64'h00FF_0000_0100_0080; pb[6] = 64'h0000_0000_0000_001F;
      pa[7] = 64'hFFFF_FFFF_FFFF_FFFE; pb[7] = 64'hFFFF_FFFF_FFFF_FFFF;

      for (int op = 0; op < 256; op++) begin
         for (int p = 0; p < 8; p++) cyc(1'b1, 8'(op), pa[p], pb[p]);
         for (int r = 0; r < 4; r++)
            cyc(1'b1, 8'(op), {$urandom, $urandom}, {$urandom, $urandom});
         if (op % 16 == 3)
            cyc(1'b0, 8'(op ^ 8'h21), {$urandom, $urandom}, {$urandom, $urandom});
      end

      // idle cycles with changing inputs after an illegal and a legal result
      cyc(1'b1, 8'hFF, 64'h1, 64'h2);
      cyc(1'b0, 8'h21, 64'h5, 64'h6);
      cyc(1'b1, 8'h21, 64'h5, 64'h6);
      cyc(1'b0, 8'h01, 64'hFFFF, 64'h3);
      cyc(1'b0, 8'h99, 64'h0, 64'h0);
      // back-to-back alternation
      for (int i = 0; i < 32; i++)
         cyc(1'(i % 3 != 0), 8'(i * 5), {$urandom, $urandom}, 64'(i));

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad_n);
      $finish;
   end
endmodule